// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words reached over a simple APB-style slave port with zero wait states. The byte address is divided by four to pick one of the words in a 768-byte window. Most words are plain storage. A few have fixed behaviour: two PLL status words come out of reset with set values, and a clock-divider word gets its reset value from two divisor parameters through a compact encoding. Address-remap words never change, and a write that tries to change one is refused. Writes to the PLL lock-status word are silently dropped.

Faults are reported in two ways. The faulting access sees `pslverr` in its access phase. Each kind of fault also sets a sticky output flag that only reset clears. A software driver polls the flags or reacts to `pslverr`. The remap flag covers refused changes to remap words. The offset flag covers writes that fall outside the window.

Top module: `sysctl_regfile`

## Requirements
- R1: After a synchronous active-low reset, word 0x90 reads 0x021A2358, word 0x150 reads 0x00000003, and every word other than these and 0x98 reads zero.
- R2: After reset, word 0x98 reads (enc(DIV_A) << 5) | (enc(DIV_B) << 2). Here enc maps 1→0, 2→1, 4→2, 8→4, 16→5, 32→6 and maps any other value to 0.
- R3: Every in-range word that is not listed in R4 or R5 stores all 32 bits of write data, and a later read at the same byte address returns them.
- R4: Writes to word 0x150 have no effect and raise no error, so it keeps reading 0x00000003.
- R5: The remap words at 0x00, 0x08 and 0x10 keep their stored value whatever data is written to them.
- R6: A write to a remap word whose data differs from its stored value asserts `pslverr` in that access phase and sets `err_remap` from the next clock. A write of equal data raises neither.
- R7: A read at byte address 0x300 or above returns zero and raises no error.
- R8: A write at byte address 0x300 or above changes no word, asserts `pslverr` in that access phase, and sets `err_offset` from the next clock.
- R9: `err_remap` and `err_offset` stay set until reset, and reset clears both.
- R10: A word is written only in the access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone changes nothing, and `pslverr` is low outside write access phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error on the current write access |
| err_remap | output | 1 | Sticky: a remap word change was refused |
| err_offset | output | 1 | Sticky: a write fell outside the window |

## Verification
The assertions run on every cycle. They check that both flags stay set once set. They check that every flag rise follows a faulting access, and that out-of-window reads return zero. They check that the lock-status word always reads 3, that `pslverr` never appears outside a write access, and that no committed write ever targets a protected or out-of-range word. The bench scenarios cover the rest. Reset values and the divisor encoding need two parameter sets. Full 32-bit storage needs a write and read-back sweep over every word. Protected words keeping their contents, and out-of-window writes not aliasing onto real words, can only be shown by reading the words back.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Word slots whose behaviour is fixed by the system around the block.
  localparam int SLOT_SRAM_MAP  = 0;   // byte 0x00
  localparam int SLOT_DDR_MAP   = 2;   // byte 0x08
  localparam int SLOT_NVM_MAP   = 4;   // byte 0x10
  localparam int SLOT_PLL_LO    = 36;  // byte 0x90
  localparam int SLOT_CLK_DIV   = 38;  // byte 0x98
  localparam int SLOT_PLL_LOCK  = 84;  // byte 0x150

  localparam logic [31:0] PLL_LO_INIT  = 32'h021A_2358;
  localparam logic [31:0] PLL_LOCK_VAL = 32'h0000_0003;

  typedef enum logic [1:0] {
    K_PLAIN  = 2'd0,
    K_RDONLY = 2'd1,
    K_GUARD  = 2'd2,
    K_VOID   = 2'd3
  } slot_kind_e;

  // Divisor to 3-bit field code; unsupported divisors give 0.
  function automatic logic [2:0] div_code(input int unsigned d);
    case (d)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd4;
      16:      return 3'd5;
      32:      return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] clkdiv_word(input int unsigned da, input int unsigned db);
    return (32'(div_code(da)) << 5) | (32'(div_code(db)) << 2);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_REGS = 192,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [IDX_W-1:0]  idx,
  output slot_kind_e        kind
);

  always_comb begin
    idx = paddr[ADDR_W-1:2];
    if (int'(idx) >= NUM_REGS) begin
      kind = K_VOID;
    end else begin
      case (int'(idx))
        SLOT_SRAM_MAP, SLOT_DDR_MAP, SLOT_NVM_MAP: kind = K_GUARD;
        SLOT_PLL_LOCK:                             kind = K_RDONLY;
        default:                                   kind = K_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          NUM_REGS   = 192,
  parameter int          IDX_W      = 8,
  parameter logic [31:0] CLKDIV_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  function automatic logic [DATA_W-1:0] reset_for(input int slot);
    case (slot)
      SLOT_PLL_LO:   return DATA_W'(PLL_LO_INIT);
      SLOT_PLL_LOCK: return DATA_W'(PLL_LOCK_VAL);
      SLOT_CLK_DIV:  return DATA_W'(CLKDIV_RST);
      default:       return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= reset_for(i);
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = (int'(ridx) < NUM_REGS) ? mem[ridx] : '0;

endmodule

// File: rtl/sysctl_errflags.sv
module sysctl_errflags (
  input  logic clk,
  input  logic rst_n,
  input  logic remap_hit,
  input  logic offset_hit,
  output logic err_remap,
  output logic err_offset
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_remap  <= 1'b0;
      err_offset <= 1'b0;
    end else begin
      if (remap_hit)  err_remap  <= 1'b1;
      if (offset_hit) err_offset <= 1'b1;
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int SPAN_BYTES = 768,
  parameter int DIV_A      = 2,
  parameter int DIV_B      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  output logic              err_remap,
  output logic              err_offset
);

  localparam int          NUM_REGS   = SPAN_BYTES / 4;
  localparam int          IDX_W      = ADDR_W - 2;
  localparam logic [31:0] CLKDIV_RST = clkdiv_word(DIV_A, DIV_B);

  // Named internal events, also used by the bound checker.
  logic [IDX_W-1:0]  commit_idx;
  slot_kind_e        kind;
  logic [DATA_W-1:0] stored;
  logic              wr_access;
  logic              wr_commit;
  logic              remap_hit;
  logic              offset_hit;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .paddr (paddr),
    .idx   (commit_idx),
    .kind  (kind)
  );

  assign wr_access  = psel && penable && pwrite;
  assign wr_commit  = wr_access && (kind == K_PLAIN);
  assign remap_hit  = wr_access && (kind == K_GUARD) && (pwdata != stored);
  assign offset_hit = wr_access && (kind == K_VOID);

  sysctl_store #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CLKDIV_RST(CLKDIV_RST)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_commit),
    .widx  (commit_idx),
    .wdata (pwdata),
    .ridx  (commit_idx),
    .rdata (stored)
  );

  sysctl_errflags u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .remap_hit  (remap_hit),
    .offset_hit (offset_hit),
    .err_remap  (err_remap),
    .err_offset (err_offset)
  );

  assign prdata  = (kind == K_VOID) ? '0 : stored;
  assign pslverr = remap_hit || offset_hit;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int SPAN_BYTES = 768
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr,
  input logic              err_remap,
  input logic              err_offset,
  input logic              wr_commit,
  input logic [ADDR_W-3:0] commit_idx
);

  localparam int NUM_REGS = SPAN_BYTES / 4;

  logic oob;
  assign oob = int'(paddr) >= SPAN_BYTES;

  a_r9_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_remap |=> err_remap);

  a_r9_offset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_offset |=> err_offset);

  a_r6_flag_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_remap) |-> $past(pslverr));

  a_r6_fault_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pslverr && !oob) |=> err_remap);

  a_r8_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && oob) |-> pslverr ##1 err_offset);

  a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && oob) |-> (prdata == '0 && !pslverr));

  a_r4_lock_reads_three: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && paddr == ADDR_W'(SLOT_PLL_LOCK * 4))
      |-> prdata == DATA_W'(PLL_LOCK_VAL));

  a_r10_err_in_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable && pwrite));

  a_r5_commit_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (int'(commit_idx) < NUM_REGS
                   && int'(commit_idx) != SLOT_SRAM_MAP
                   && int'(commit_idx) != SLOT_DDR_MAP
                   && int'(commit_idx) != SLOT_NVM_MAP
                   && int'(commit_idx) != SLOT_PLL_LOCK));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPAN_BYTES(SPAN_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .prdata     (prdata),
  .pslverr    (pslverr),
  .err_remap  (err_remap),
  .err_offset (err_offset),
  .wr_commit  (wr_commit),
  .commit_idx (commit_idx)
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_alt;
  logic        pslverr, err_remap, err_offset;
  logic        pslverr_alt, err_remap_alt, err_offset_alt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysctl_regfile #(.DIV_A(8), .DIV_B(32)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .err_remap(err_remap), .err_offset(err_offset)
  );

  // Second configuration: one valid and one unsupported divisor.
  sysctl_regfile #(.DIV_A(16), .DIV_B(3)) uut_alt (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_alt), .pslverr(pslverr_alt),
    .err_remap(err_remap_alt), .err_offset(err_offset_alt)
  );

  // Divisor code computed from the exponent: 2^p -> p for p<3, p+1 for p in 3..5.
  function automatic int enc(input int d);
    for (int p = 0; p < 6; p++) if (d == (1 << p)) return (p < 3) ? p : p + 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_reset(input int i, input int da, input int db);
    if (i == 36) return 32'h021A2358;
    if (i == 84) return 32'h3;
    if (i == 38) return 32'(enc(da) * 32 + enc(db) * 4);
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0F00 ^ (32'(i) * 32'h0101_0101) ^ {32'(i), 24'h0}[31:0];
  endfunction

  function automatic bit guarded(input int i);
    return (i == 0) || (i == 2) || (i == 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1 err = pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d, output logic [31:0] d_alt);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata; d_alt = prdata_alt;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    logic e;
    do_reset();

    // R1 / R2: reset image of every word.
    for (int i = 0; i < 192; i++) begin
      bus_read(10'(i * 4), rd, rd2);
      if (i == 38) chk("R2 clkdiv reset", rd, exp_reset(i, 8, 32));
      else chk("R1 reset word", rd, exp_reset(i, 8, 32));
      if (i == 38) chk("R2 clkdiv reset alt config", rd2, exp_reset(i, 16, 3));
    end
    chk("R9 flags clear after reset", {30'h0, err_remap, err_offset}, 32'h0);

    // R6: equal-data write to a remap word is quiet.
    bus_write(10'h000, 32'h0, e);
    chk("R6 equal write no pslverr", {31'h0, e}, 32'h0);
    chk("R6 equal write no flag", {31'h0, err_remap}, 32'h0);

    // R3/R4/R5/R6: write sweep over all words.
    for (int i = 0; i < 192; i++) begin
      bus_write(10'(i * 4), pat(i), e);
      chk(guarded(i) ? "R6 remap pslverr" : "R4 R3 no pslverr", {31'h0, e},
          {31'h0, guarded(i)});
    end
    chk("R6 err_remap set", {31'h0, err_remap}, 32'h1);
    chk("R8 err_offset still clear", {31'h0, err_offset}, 32'h0);

    // R10: setup phase only, no access phase.
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 10'(10 * 4); pwdata = 32'hDEAD_BEEF;
    @(negedge clk); psel = 0; pwrite = 0;
    chk("R10 no pslverr in setup", {31'h0, pslverr}, 32'h0);

    // R7 / R8: out-of-window reads and writes.
    for (int a = 'h300; a < 'h400; a += 4) begin
      bus_read(10'(a), rd, rd2);
      chk("R7 oob read zero", rd, 32'h0);
    end
    chk("R7 oob read no flag", {31'h0, err_offset}, 32'h0);
    for (int a = 'h300; a < 'h400; a += 4) begin
      bus_write(10'(a), 32'hFFFF_FFFF, e);
      chk("R8 oob write pslverr", {31'h0, e}, 32'h1);
    end
    chk("R8 err_offset set", {31'h0, err_offset}, 32'h1);

    // Read back: R3 storage, R4 lock word, R5 remap words, R8/R10 no disturbance.
    for (int i = 0; i < 192; i++) begin
      bus_read(10'(i * 4), rd, rd2);
      if (guarded(i)) chk("R5 remap word unchanged", rd, 32'h0);
      else if (i == 84) chk("R4 lock word", rd, 32'h3);
      else chk("R3 R8 R10 stored word", rd, pat(i));
    end

    // R9: sticky across clean traffic, cleared by reset.
    bus_write(10'h040, 32'h1234_5678, e);
    bus_read(10'h040, rd, rd2);
    chk("R3 rewrite", rd, 32'h1234_5678);
    chk("R9 flags held", {30'h0, err_remap, err_offset}, 32'h3);
    do_reset();
    chk("R9 flags cleared by reset", {30'h0, err_remap, err_offset}, 32'h0);
    bus_read(10'h090, rd, rd2);
    chk("R1 pll low after second reset", rd, 32'h021A2358);
    bus_read(10'h040, rd, rd2);
    chk("R1 plain word zero after reset", rd, 32'h0);
    bus_read(10'h098, rd, rd2);
    chk("R2 clkdiv after second reset", rd, exp_reset(38, 8, 32));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule